// File: doc/BRIEF.md
# Write Leveling Feedback Responder

This block stands in for the memory device during write leveling. It decodes mode register writes to find out when leveling starts and stops and whether the feedback drivers are enabled. It switches strobe and data termination from the ODT input. Each byte lane watches its own data strobe. On every rising strobe edge the lane captures the level of the device clock. After a fixed number of reference clock cycles it returns that level on all of its data bits.

A controller model or a leveling engine under test sweeps its strobe delay against this responder. It looks for the sampled level to change from 0 to 1. A wide configuration has several lanes, and they run independently, so each lane can be trained on its own. While leveling is active, the responder reports any command other than a no-operation, a deselect, or the mode register write that ends leveling.

Top module: `wl_responder`

## Requirements
- R1: A mode register write (cmd code 3'd2) with `mr_sel` equal to 1 and `mr_addr[7]` set enters leveling. A later such write with `mr_addr[7]` clear leaves it. `dq_oe` is high exactly while leveling is active and the drivers are enabled, and it changes one cycle after the write.
- R2: `mr_addr[12]` of that same write disables the feedback drivers when it is 1. While it is set, `dq_oe` stays low and `dq` stays all zero even when strobes arrive.
- R3: `dqs_term` follows `odt` one cycle later in every mode. `dq_term` follows `odt` one cycle later outside leveling, and stays 0 while leveling is active.
- R4: A rising edge of a lane's `dqs` bit, first seen at clock edge e, captures `ck_sense`. From edge e+TWLO onward the lane drives that level on all LANE_W bits. The lane keeps its previous value through edge e+TWLO-1.
- R5: A lane's feedback holds its last value until a later strobe result replaces it.
- R6: Lanes are independent. Lane l occupies `dq[l*LANE_W +: LANE_W]` and responds only to `dqs[l]`.
- R7: While leveling is active, cmd codes 3..7, and any mode register write other than the exit write, pulse `ill_cmd` high for one cycle, starting one cycle after the command. These commands do not change the mode. Codes 3'd0 (no-op) and 3'd1 (deselect) are legal and raise no flag. Outside leveling, `ill_cmd` stays low.
- R8: After entering leveling, `dq` reads all zero until the first strobe result. Strobe edges outside leveling have no effect on `dq`.
- R9: On leaving leveling, `dq` returns to all zero one cycle after `dq_oe` falls, and results still in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code: 0 no-op, 1 deselect, 2 mode register write, 3..7 other commands |
| mr_sel | input | MRS_W (2) | Mode register index for a mode register write |
| mr_addr | input | ADDR_W (16) | Mode register write value |
| odt | input | 1 | Termination request |
| ck_sense | input | 1 | Device clock level presented to the strobe samplers |
| dqs | input | LANES (2) | One strobe per byte lane |
| dq | output | LANES*LANE_W (16) | Feedback data, one replicated bit per lane |
| dq_oe | output | 1 | Feedback drivers enabled |
| dqs_term | output | 1 | Strobe termination enabled |
| dq_term | output | 1 | Data termination enabled |
| ill_cmd | output | 1 | Illegal command seen during leveling |

## Verification
Each strobe result is due exactly TWLO edges after the edge that first sees the strobe high. When the driver task raises a strobe, it queues two entries for that lane. One expects the old value at edge e+TWLO-1, and the other expects the new level at edge e+TWLO. The monitor pops each entry at the falling edge of its due cycle. Termination, `ill_cmd` and the mode-dependent outputs are due one edge after their stimulus, except the return of `dq` to zero on exit, which is due two edges later. The direct checks sample those outputs at the falling edge that follows.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_DES = 3'd1,
    CMD_MRS = 3'd2,
    CMD_ACT = 3'd3,
    CMD_RD  = 3'd4,
    CMD_WR  = 3'd5,
    CMD_PRE = 3'd6,
    CMD_REF = 3'd7
  } cmd_e;

  localparam int LVL_MR_IDX = 1;   // register that owns the leveling bits
  localparam int LVL_EN_BIT = 7;   // leveling enable
  localparam int QOFF_BIT   = 12;  // output drivers off
endpackage

// File: rtl/wl_mode_ctl.sv
module wl_mode_ctl
  import wl_pkg::*;
#(
  parameter int MRS_W  = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [MRS_W-1:0]  mr_sel,
  input  logic [ADDR_W-1:0] mr_addr,
  output logic              wl_mode,
  output logic              qoff,
  output logic              ill_cmd
);
  logic is_lvl_mr;
  logic legal;

  always_comb begin
    is_lvl_mr = (cmd == CMD_MRS) && (mr_sel == MRS_W'(LVL_MR_IDX));
    legal     = (cmd == CMD_NOP) || (cmd == CMD_DES) ||
                (is_lvl_mr && !mr_addr[LVL_EN_BIT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_mode <= 1'b0;
      qoff    <= 1'b0;
      ill_cmd <= 1'b0;
    end else begin
      ill_cmd <= 1'b0;
      if (wl_mode) begin
        if (!legal) begin
          ill_cmd <= 1'b1;
        end else if (is_lvl_mr) begin
          wl_mode <= 1'b0;
          qoff    <= mr_addr[QOFF_BIT];
        end
      end else if (is_lvl_mr) begin
        wl_mode <= mr_addr[LVL_EN_BIT];
        qoff    <= mr_addr[QOFF_BIT];
      end
    end
  end

  AST_ILL_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    ill_cmd |-> (wl_mode && $stable(wl_mode))) else $error("illegal command changed mode"); // R7
endmodule

// File: rtl/wl_term.sv
module wl_term (
  input  logic clk,
  input  logic rst,
  input  logic wl_mode,
  input  logic odt,
  output logic dqs_term,
  output logic dq_term
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_term <= 1'b0;
      dq_term  <= 1'b0;
    end else begin
      dqs_term <= odt;
      dq_term  <= odt && !wl_mode;
    end
  end
endmodule

// File: rtl/wl_lane.sv
module wl_lane #(
  parameter int LANE_W = 8,
  parameter int TWLO   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wl_mode,
  input  logic              drv_en,
  input  logic              dqs,
  input  logic              ck_sense,
  output logic [LANE_W-1:0] dq
);
  localparam int DEPTH = (TWLO < 1) ? 1 : TWLO;

  logic             dqs_q;
  logic             rise;
  logic [DEPTH-1:0] pv;
  logic [DEPTH-1:0] pb;

  assign rise = dqs && !dqs_q && wl_mode;

  always_ff @(posedge clk) begin
    if (rst) dqs_q <= 1'b0;
    else     dqs_q <= dqs;
  end

  always_ff @(posedge clk) begin
    if (rst || !wl_mode) begin
      pv <= '0;
      pb <= '0;
    end else begin
      pv[0] <= rise;
      pb[0] <= ck_sense;
      for (int i = 1; i < DEPTH; i++) begin
        pv[i] <= pv[i-1];
        pb[i] <= pb[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !drv_en) dq <= '0;
    else if (pv[DEPTH-1]) dq <= {LANE_W{pb[DEPTH-1]}};
  end

  AST_NO_CAPTURE_OUT_OF_MODE: assert property (@(posedge clk) disable iff (rst)
    !wl_mode |=> !pv[0]) else $error("strobe captured outside leveling"); // R8
  AST_DQ_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !drv_en |=> (dq == '0)) else $error("feedback driven while disabled"); // R2
  AST_DQ_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (dq == '0) || (dq == '1)) else $error("lane bits disagree"); // R4
endmodule

// File: rtl/wl_responder.sv
module wl_responder
  import wl_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int TWLO   = 4,
  parameter int MRS_W  = 2,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              cmd,
  input  logic [MRS_W-1:0]        mr_sel,
  input  logic [ADDR_W-1:0]       mr_addr,
  input  logic                    odt,
  input  logic                    ck_sense,
  input  logic [LANES-1:0]        dqs,
  output logic [LANES*LANE_W-1:0] dq,
  output logic                    dq_oe,
  output logic                    dqs_term,
  output logic                    dq_term,
  output logic                    ill_cmd
);
  logic wl_mode;
  logic qoff;

  wl_mode_ctl #(.MRS_W(MRS_W), .ADDR_W(ADDR_W)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd_e'(cmd)),
    .mr_sel  (mr_sel),
    .mr_addr (mr_addr),
    .wl_mode (wl_mode),
    .qoff    (qoff),
    .ill_cmd (ill_cmd)
  );

  assign dq_oe = wl_mode && !qoff;

  wl_term u_term (
    .clk      (clk),
    .rst      (rst),
    .wl_mode  (wl_mode),
    .odt      (odt),
    .dqs_term (dqs_term),
    .dq_term  (dq_term)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wl_lane #(.LANE_W(LANE_W), .TWLO(TWLO)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .wl_mode  (wl_mode),
      .drv_en   (dq_oe),
      .dqs      (dqs[l]),
      .ck_sense (ck_sense),
      .dq       (dq[l*LANE_W +: LANE_W])
    );
  end

  AST_DQTERM_OFF_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    wl_mode |=> !dq_term) else $error("data termination on during leveling"); // R3
  AST_DQS_TERM_TRACKS_ODT: assert property (@(posedge clk) disable iff (rst)
    odt |=> dqs_term) else $error("strobe termination missed ODT"); // R3
endmodule

// File: tb/wl_responder_tb.sv
module wl_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int TWLO   = 4;

  typedef struct {
    int                due;
    int                lane;
    logic [LANE_W-1:0] val;
    string             req;
  } sb_item_t;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [2:0]              cmd = 3'd0;
  logic [1:0]              mr_sel = '0;
  logic [15:0]             mr_addr = '0;
  logic                    odt = 1'b0;
  logic                    ck_sense = 1'b0;
  logic [LANES-1:0]        dqs = '0;
  logic [LANES*LANE_W-1:0] dq;
  logic                    dq_oe, dqs_term, dq_term, ill_cmd;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  sb_item_t sb[$];
  logic [LANE_W-1:0] exp_lane [LANES];
  bit drv_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wl_responder #(.LANES(LANES), .LANE_W(LANE_W), .TWLO(TWLO)) u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .mr_sel(mr_sel), .mr_addr(mr_addr),
    .odt(odt), .ck_sense(ck_sense), .dqs(dqs), .dq(dq), .dq_oe(dq_oe),
    .dqs_term(dqs_term), .dq_term(dq_term), .ill_cmd(ill_cmd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pops scoreboard entries at their due cycle
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          chk(sb[i].req, 32'(dq[sb[i].lane*LANE_W +: LANE_W]), 32'(sb[i].val));
          sb.delete(i);
        end
      end
    end
  end

  task automatic mrs(input logic [1:0] sel, input logic lvl, input logic qo);
    cmd = 3'd2;
    mr_sel = sel;
    mr_addr = '0;
    mr_addr[7] = lvl;
    mr_addr[12] = qo;
    step();
    cmd = 3'd0;
    mr_addr = '0;
  endtask

  // driver: raise one strobe, queue the old and new values around the due edge
  task automatic strobe(input int l, input logic ck, input string req);
    sb_item_t it;
    logic [LANE_W-1:0] nv;
    nv = drv_on ? {LANE_W{ck}} : '0;
    it.lane = l;
    it.req  = req;
    it.due  = cyc + TWLO;     it.val = exp_lane[l]; sb.push_back(it);
    it.due  = cyc + 1 + TWLO; it.val = nv;          sb.push_back(it);
    exp_lane[l] = nv;
    dqs[l] = 1'b1;
    ck_sense = ck;
    step();
    dqs[l] = 1'b0;
    step();
  endtask

  task automatic drain();
    repeat (TWLO + 3) step();
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) exp_lane[l] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    chk("R1 reset oe", 32'(dq_oe), 0);
    chk("R8 reset dq", 32'(dq), 0);
    chk("R7 reset ill", 32'(ill_cmd), 0);
    chk("R3 reset term", 32'({dqs_term, dq_term}), 0);

    // strobe outside leveling: no effect
    strobe(0, 1'b1, "R8 out-of-mode strobe");
    drain();
    chk("R8 dq after out-of-mode strobe", 32'(dq), 0);

    // illegal command outside leveling is not flagged
    cmd = 3'd4; step(); cmd = 3'd0;
    chk("R7 no flag outside mode", 32'(ill_cmd), 0);

    // termination outside leveling
    odt = 1'b1; step();
    chk("R3 dqs_term normal", 32'(dqs_term), 1);
    chk("R3 dq_term normal", 32'(dq_term), 1);

    // enter leveling
    mrs(2'd1, 1'b1, 1'b0);
    drv_on = 1'b1;
    chk("R1 oe after entry", 32'(dq_oe), 1);
    step();
    chk("R8 dq zero after entry", 32'(dq), 0);
    chk("R3 dq_term off in mode", 32'(dq_term), 0);
    chk("R3 dqs_term on in mode", 32'(dqs_term), 1);
    odt = 1'b0; step();
    chk("R3 dqs_term off in mode", 32'(dqs_term), 0);
    chk("R3 dq_term stays off", 32'(dq_term), 0);

    // per-lane capture and latency
    strobe(0, 1'b1, "R4 lane0 high");
    drain();
    strobe(1, 1'b1, "R4 lane1 high");
    drain();
    strobe(0, 1'b0, "R6 lane0 low, lane1 untouched");
    drain();
    chk("R6 lane1 holds while lane0 moves", 32'(dq[LANE_W +: LANE_W]), 32'({LANE_W{1'b1}}));
    strobe(1, 1'b0, "R4 lane1 low");
    strobe(0, 1'b1, "R6 overlapping lane0 high");
    drain();

    // back-to-back strobes on one lane
    strobe(0, 1'b0, "R4 back-to-back a");
    strobe(0, 1'b1, "R4 back-to-back b");
    drain();

    // hold
    repeat (12) step();
    chk("R5 lane0 holds", 32'(dq[0 +: LANE_W]), 32'({LANE_W{1'b1}}));
    chk("R5 lane1 holds", 32'(dq[LANE_W +: LANE_W]), 0);

    // illegal commands in mode
    cmd = 3'd3; step(); cmd = 3'd0;
    chk("R7 ACT flagged", 32'(ill_cmd), 1);
    step();
    chk("R7 flag is a pulse", 32'(ill_cmd), 0);
    chk("R7 mode kept after ACT", 32'(dq_oe), 1);
    mrs(2'd0, 1'b0, 1'b0);
    chk("R7 other MR flagged", 32'(ill_cmd), 1);
    chk("R7 mode kept after other MR", 32'(dq_oe), 1);
    mrs(2'd1, 1'b1, 1'b1);
    chk("R7 re-entry write flagged", 32'(ill_cmd), 1);
    chk("R7 re-entry write ignored", 32'(dq_oe), 1);
    cmd = 3'd1; step(); cmd = 3'd0;
    chk("R7 deselect legal", 32'(ill_cmd), 0);
    step();
    chk("R7 nop legal", 32'(ill_cmd), 0);

    // exit with a result in flight
    dqs[1] = 1'b1; ck_sense = 1'b1; step(); dqs[1] = 1'b0;
    mrs(2'd1, 1'b0, 1'b0);
    drv_on = 1'b0;
    chk("R1 oe off after exit", 32'(dq_oe), 0);
    chk("R7 exit write legal", 32'(ill_cmd), 0);
    step();
    chk("R9 dq cleared after exit", 32'(dq), 0);
    drain();
    chk("R9 in-flight result dropped", 32'(dq), 0);
    for (int l = 0; l < LANES; l++) exp_lane[l] = '0;

    // output drivers off
    mrs(2'd1, 1'b1, 1'b1);
    chk("R2 oe low with drivers off", 32'(dq_oe), 0);
    strobe(0, 1'b1, "R2 no feedback with drivers off");
    strobe(1, 1'b1, "R2 no feedback lane1");
    drain();
    mrs(2'd1, 1'b0, 1'b0);

    // re-entry starts clean
    mrs(2'd1, 1'b1, 1'b0);
    drv_on = 1'b1;
    step();
    chk("R8 dq zero on re-entry", 32'(dq), 0);
    strobe(1, 1'b1, "R4 after re-entry");
    drain();

    chk("R4 scoreboard empty", 32'(sb.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule